// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block owns the program counter of a 32-bit processor and decides, once per accepted instruction, where execution goes next. The decode stage presents an advance strobe together with a small control code that names the flow type, a sign-extended byte offset, and the current value of the one register a conditional branch tests. The unit either steps the counter past the current instruction or adds the offset to the counter. A conditional branch adds the offset only when the tested value is negative, strictly positive, or zero, depending on the code.

A halt code parks the unit. The counter moves past the halt instruction and then freezes, and a status output reports the halted state. Advance strobes have no effect while the unit is halted. A high level on the interrupt input returns the unit to normal operation, so execution resumes at the instruction after the halt. The reset input is asynchronous and active low. Its release is synchronised internally.

Top module: `npc_unit`

## Requirements
- R1: While reset is held, and after its synchronised release, `pc_o` is 0 and `halted_o` is 0.
- R2: When the unit is running and `adv_i` is 0, an edge leaves `pc_o` unchanged and `halted_o` low, whatever the code, offset and tested value are.
- R3: When the unit is running and `adv_i` is 1, codes 0 (sequential/no-op), 6 and 7 set `pc_o` to `pc_o + 4`, modulo 2^32.
- R4: When the unit is running and `adv_i` is 1, code 1 (always-branch) sets `pc_o` to `pc_o + ofs_i`. The offset is taken as two's complement and the sum is modulo 2^32.
- R5: Code 2 (branch-if-minus) adds `ofs_i` when bit 31 of `tst_i` is 1. Otherwise it adds 4.
- R6: Code 3 (branch-if-plus) adds `ofs_i` only when `tst_i` is non-zero and bit 31 of `tst_i` is 0. When `tst_i` is zero or negative, it adds 4.
- R7: Code 4 (branch-if-zero) adds `ofs_i` only when `tst_i` equals 0. Otherwise it adds 4.
- R8: Code 5 (halt) with `adv_i` sets `pc_o` to `pc_o + 4` and raises `halted_o` on the same edge.
- R9: While `halted_o` is 1 and `irq_i` is 0, `pc_o` and `halted_o` keep their values, even when `adv_i` is 1 with any code.
- R10: While `halted_o` is 1, `irq_i` at an edge clears `halted_o` and leaves `pc_o` unchanged, so the next accepted advance continues from the instruction after the halt. While the unit is running, `irq_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| adv_i | input | 1 | Advance strobe: one instruction is accepted at this edge |
| kind_i | input | 3 | Flow code: 0 seq, 1 always, 2 minus, 3 plus, 4 zero, 5 halt, 6/7 seq |
| ofs_i | input | 32 | Sign-extended branch byte offset |
| tst_i | input | 32 | Value of the register a conditional branch tests |
| irq_i | input | 1 | Interrupt level that releases the halted state |
| pc_o | output | 32 | Current program counter |
| halted_o | output | 1 | High while the unit is halted |

## Verification
Each of the eight flow codes is applied with tested values chosen around the sign and zero boundaries: 0, 1, -1, the largest positive value, the most negative value, and small values of either sign. These show whether plus is strict, whether minus reads only the sign bit, and whether zero fails for any non-zero value. Each code and test value is also paired with offsets of 0, positive, negative and near the wrap point. These separate an offset add from a step of 4 and check the modulo arithmetic. Halt sequences send advance strobes while the unit is halted and interrupts while it is running, so a frozen counter can be told apart from a resumed one.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_JMP  = 3'd1,
    FLOW_NEG  = 3'd2,
    FLOW_POS  = 3'd3,
    FLOW_ZERO = 3'd4,
    FLOW_HALT = 3'd5,
    FLOW_RSV6 = 3'd6,
    FLOW_RSV7 = 3'd7
  } flow_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_PARK = 1'b1
  } run_state_e;
endpackage

// File: rtl/npc_rst_sync.sv
`timescale 1ns/1ps
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = chain_q[STAGES-1];
endmodule

// File: rtl/npc_cond.sv
`timescale 1ns/1ps
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e            kind,
  input  logic [XLEN-1:0]  tst,
  output logic             use_ofs,
  output logic             is_halt
);
  logic sign_set;
  logic all_zero;
  logic strictly_pos;

  assign sign_set     = tst[XLEN-1];
  assign all_zero     = (tst == '0);
  assign strictly_pos = !sign_set && !all_zero;

  always_comb begin
    use_ofs = 1'b0;
    is_halt = 1'b0;
    unique case (kind)
      FLOW_JMP:  use_ofs = 1'b1;
      FLOW_NEG:  use_ofs = sign_set;
      FLOW_POS:  use_ofs = strictly_pos;
      FLOW_ZERO: use_ofs = all_zero;
      FLOW_HALT: is_halt = 1'b1;
      default:   use_ofs = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] ofs,
  input  logic            use_ofs,
  output logic [XLEN-1:0] pc_next
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  logic [XLEN-1:0] addend;

  assign addend  = use_ofs ? ofs : STEP_V;
  assign pc_next = pc + addend;
endmodule

// File: rtl/npc_ctrl.sv
`timescale 1ns/1ps
module npc_ctrl
  import npc_pkg::*;
(
  input  logic clk,
  input  logic rst_ok,
  input  logic adv,
  input  logic is_halt,
  input  logic irq,
  output logic pc_en,
  output logic parked
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (adv && is_halt) state_d = ST_PARK;
      ST_PARK: if (irq)            state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign pc_en  = (state_q == ST_RUN) && adv;
  assign parked = (state_q == ST_PARK);
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  input  logic [2:0]      kind_i,
  input  logic [XLEN-1:0] ofs_i,
  input  logic [XLEN-1:0] tst_i,
  input  logic            irq_i,
  output logic [XLEN-1:0] pc_o,
  output logic            halted_o
);
  logic            rst_ok;
  logic            use_ofs;
  logic            is_halt;
  logic            pc_en;
  logic [XLEN-1:0] pc_q, pc_d;
  flow_e           kind;

  assign kind = flow_e'(kind_i);

  npc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind(kind), .tst(tst_i), .use_ofs(use_ofs), .is_halt(is_halt)
  );

  npc_target #(.XLEN(XLEN), .STEP(STEP)) u_tgt (
    .pc(pc_q), .ofs(ofs_i), .use_ofs(use_ofs), .pc_next(pc_d)
  );

  npc_ctrl u_ctrl (
    .clk(clk), .rst_ok(rst_ok), .adv(adv_i), .is_halt(is_halt),
    .irq(irq_i), .pc_en(pc_en), .parked(halted_o)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            adv_i,
  input logic [2:0]      kind_i,
  input logic [XLEN-1:0] ofs_i,
  input logic            irq_i,
  input logic [XLEN-1:0] pc_o,
  input logic            halted_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_ok |-> (pc_o == '0 && !halted_o));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!halted_o && !adv_i) |=> ($stable(pc_o) && !halted_o));

  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (!halted_o && adv_i && (kind_i == 3'd0 || kind_i >= 3'd6))
      |=> (pc_o == $past(pc_o) + STEP_V));

  a_r4_jump_add: assert property (@(posedge clk) disable iff (!rst_ok)
    (!halted_o && adv_i && kind_i == 3'd1) |=> (pc_o == $past(pc_o) + $past(ofs_i)));

  a_r8_halt_entry: assert property (@(posedge clk) disable iff (!rst_ok)
    (!halted_o && adv_i && kind_i == 3'd5) |=> (halted_o && pc_o == $past(pc_o) + STEP_V));

  a_r9_parked_freeze: assert property (@(posedge clk) disable iff (!rst_ok)
    (halted_o && !irq_i) |=> ($stable(pc_o) && halted_o));

  a_r10_irq_release: assert property (@(posedge clk) disable iff (!rst_ok)
    (halted_o && irq_i) |=> (!halted_o && $stable(pc_o)));

  a_r10_irq_running: assert property (@(posedge clk) disable iff (!rst_ok)
    (!halted_o && !(adv_i && kind_i == 3'd5)) |=> !halted_o);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .adv_i(adv_i), .kind_i(kind_i), .ofs_i(ofs_i),
  .irq_i(irq_i), .pc_o(pc_o), .halted_o(halted_o)
);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv_i;
  logic [2:0]  kind_i;
  logic [31:0] ofs_i;
  logic [31:0] tst_i;
  logic        irq_i;
  logic [31:0] pc_o;
  logic        halted_o;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  logic [31:0] exp_pc;
  logic        exp_halt;

  always #5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_i), .kind_i(kind_i), .ofs_i(ofs_i),
    .tst_i(tst_i), .irq_i(irq_i), .pc_o(pc_o), .halted_o(halted_o)
  );

  task automatic check(input string req);
    n_run++;
    if (pc_o !== exp_pc || halted_o !== exp_halt) begin
      n_fail++;
      $display("FAIL %s: pc=%h halted=%b expected pc=%h halted=%b",
               req, pc_o, halted_o, exp_pc, exp_halt);
    end
  endtask

  function automatic string tag_of(input logic a, input logic [2:0] k, input logic h);
    if (h)     return "R9";
    if (!a)    return "R2";
    case (k)
      3'd1:    return "R4";
      3'd2:    return "R5";
      3'd3:    return "R6";
      3'd4:    return "R7";
      3'd5:    return "R8";
      default: return "R3";
    endcase
  endfunction

  // apply one cycle of stimulus, update the model, check one cycle later
  task automatic step(input logic a, input logic [2:0] k, input logic [31:0] o,
                      input logic [31:0] t, input logic q, input string req);
    logic take;
    adv_i = a; kind_i = k; ofs_i = o; tst_i = t; irq_i = q;
    if (exp_halt) begin
      if (q) exp_halt = 1'b0;
    end else if (a) begin
      case (k)
        3'd1:    take = 1'b1;
        3'd2:    take = ($signed(t) < 0);
        3'd3:    take = ($signed(t) > 0);
        3'd4:    take = (t == 32'd0);
        default: take = 1'b0;
      endcase
      exp_pc = take ? exp_pc + o : exp_pc + 32'd4;
      if (k == 3'd5) exp_halt = 1'b1;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: pc=%h halted=%b expected completion", pc_o, halted_o);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] tv [7];
    logic [31:0] ov [5];
    tv = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'd5, 32'hFFFF_FFFB};
    ov = '{32'd0, 32'd10, 32'hFFFF_FFB5, 32'hFFFF_FFFC, 32'h7FFF_FFFC};
    rst_n = 1'b0; adv_i = 1'b1; kind_i = 3'd1; ofs_i = 32'd8; tst_i = '0; irq_i = 1'b0;
    exp_pc = '0; exp_halt = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    adv_i = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");

    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 7; i++) begin
        for (int j = 0; j < 5; j++) begin
          step(1'b1, 3'(k), ov[j], tv[i], 1'b0, tag_of(1'b1, 3'(k), 1'b0));
          if (exp_halt) begin
            step(1'b1, 3'd1, ov[j], tv[i], 1'b0, "R9");
            step(1'b0, 3'd1, ov[j], tv[i], 1'b1, "R10");
          end
          step(1'b0, 3'(k), ov[j] ^ 32'h55, tv[i], 1'b0, "R2");
        end
      end
    end

    // interrupt while running: no effect
    step(1'b0, 3'd0, 32'd0, 32'd0, 1'b1, "R10");
    step(1'b1, 3'd0, 32'd0, 32'd0, 1'b1, "R10");
    // longer halt with strobes of every code ignored
    step(1'b1, 3'd5, 32'd40, 32'd0, 1'b0, "R8");
    for (int k = 0; k < 8; k++) step(1'b1, 3'(k), 32'd64, 32'd0, 1'b0, "R9");
    step(1'b1, 3'd1, 32'd64, 32'd0, 1'b1, "R10");
    step(1'b1, 3'd0, 32'd64, 32'd0, 1'b0, "R10");
    step(1'b1, 3'd1, 32'hFFFF_FF00, 32'd0, 1'b0, "R4");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule